// File: doc/BRIEF.md
# Host Interrupt Line Generator

This block produces the three interrupt request lines that a keyboard/mouse/power-management mailbox presents to a host processor. The keyboard and mouse channels share a single output-buffer-full flag. A separate select input records which data register, keyboard or mouse, was written last, and that input steers the flag onto the matching line. The power-management channel has a flag of its own. A per-line enable picks the driver of each line. With the enable set, the line is driven by hardware from its buffer-full condition. With it clear, the line copies a bit written by firmware.

A 2-bit mode field sets how the hardware-driven lines behave. A value of zero gives level signalling: the line is high while the request stands and falls when the host empties the buffer. Any nonzero value gives edge signalling: the line idles high and drops for a fixed number of clocks when a request appears. The mode value sets that pulse width. A global polarity bit inverts every hardware-driven level. The current pin levels are also returned on a readback bus for firmware.

All pin outputs come from flops and change one clock after the inputs that cause them.

Top module: `hostirq_gen`

## Requirements
- R1: While `rst_n` is low, `irq_pin` and `irq_rdbk` are 3'b000.
- R2: When `hw_en[i]` is 0, `irq_pin[i]` equals `fw_lvl[i]` one clock later. The flags, the mode field and `inv_pol` have no effect on that line.
- R3: Line bit 0 is keyboard, bit 1 is mouse, bit 2 is power management. The shared flag `obf_kbm` raises the keyboard request when `last_wr_mouse` is 0 and the mouse request when it is 1, never both at once. `obf_pm` raises the power-management request.
- R4: With `pulse_mode` = 0 and `hw_en[i]` = 1 (`inv_pol` = 0), `irq_pin[i]` is high exactly when that line's request was present at the previous clock edge.
- R5: With `pulse_mode` != 0 and `hw_en[i]` = 1 (`inv_pol` = 0), the line idles high. When the request rises, the line goes low starting at the next clock edge.
- R6: The low pulse lasts 4 × 2^(N−1) clocks for `pulse_mode` = N, which gives 4, 8 and 16 clocks for N = 1, 2 and 3.
- R7: A new request rise while a pulse is running neither restarts nor lengthens that pulse.
- R8: With `inv_pol` = 1, every hardware-driven line shows the exact inverse of its `inv_pol` = 0 level, in both level and edge mode.
- R9: `irq_rdbk` always equals `irq_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obf_kbm | input | 1 | Shared keyboard/mouse output-buffer-full flag |
| last_wr_mouse | input | 1 | 1: mouse data register written last; 0: keyboard |
| obf_pm | input | 1 | Power-management output-buffer-full flag |
| hw_en | input | 3 | Per-line hardware drive enable (bit0 kbd, bit1 mouse, bit2 pm) |
| fw_lvl | input | 3 | Firmware-written line levels |
| pulse_mode | input | 2 | 0 = level, N>0 = edge with 4·2^(N−1) clock pulse |
| inv_pol | input | 1 | Inverts hardware-driven lines |
| irq_pin | output | 3 | Interrupt lines to the host |
| irq_rdbk | output | 3 | Readback of pin levels |

## Verification
Every line holds a last-request flop and a pulse down-counter. A corrupted request flop either produces a pulse with no cause or misses a real rise, and the pin shows this one clock after the request changes. A counter that loads the wrong value or reloads during a pulse moves the pulse's rising edge, which becomes visible at the end of the pulse, at most 16 clocks later. A reference model in the bench predicts every pin on every clock, so each of these faults is reported on the first clock where the pin differs.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;
  localparam int unsigned NUM_LINES  = 3;
  localparam int unsigned LINE_KBD   = 0;
  localparam int unsigned LINE_MOUSE = 1;
  localparam int unsigned LINE_PM    = 2;
endpackage

// File: rtl/hostirq_steer.sv
module hostirq_steer
  import hostirq_pkg::*;
(
  input  logic                 obf_kbm,
  input  logic                 last_wr_mouse,
  input  logic                 obf_pm,
  output logic [NUM_LINES-1:0] req
);
  // R3: the shared flag feeds only the line whose data register was written last
  always_comb begin
    req             = '0;
    req[LINE_KBD]   = obf_kbm & ~last_wr_mouse;
    req[LINE_MOUSE] = obf_kbm &  last_wr_mouse;
    req[LINE_PM]    = obf_pm;
  end
endmodule

// File: rtl/hostirq_width.sv
module hostirq_width #(
  parameter int unsigned MODE_W   = 2,
  parameter int unsigned BASE_CYC = 4,
  parameter int unsigned CNT_W    = 5
) (
  input  logic [MODE_W-1:0] pulse_mode,
  output logic              edge_sel,
  output logic [CNT_W-1:0]  width
);
  // R6: width = BASE_CYC * 2^(mode-1) for nonzero mode
  always_comb begin
    edge_sel = |pulse_mode;
    width    = '0;
    if (edge_sel) begin
      width = CNT_W'(BASE_CYC) << (pulse_mode - MODE_W'(1));
    end
  end
endmodule

// File: rtl/hostirq_line.sv
module hostirq_line #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             hw_en,
  input  logic             fw_lvl,
  input  logic             edge_sel,
  input  logic [CNT_W-1:0] width,
  input  logic             inv_pol,
  output logic             pin
);
  logic             req_q;
  logic             pin_q;
  logic             pin_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             req_rise;
  logic             busy;
  logic             hw_lvl;

  always_comb begin
    req_rise = req & ~req_q;
    busy     = (cnt_q != '0);
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    if (busy) begin
      // R7: a running pulse only counts down, it never reloads
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end else if (hw_en && edge_sel && req_rise) begin
      cnt_d  = width;
      cnt_en = 1'b1;
    end
    hw_lvl = edge_sel ? (cnt_d == '0) : req;
    pin_d  = hw_en ? (hw_lvl ^ inv_pol) : fw_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
      pin_q <= 1'b0;
    end else begin
      req_q <= req;
      pin_q <= pin_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign pin = pin_q;

  p_fw_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_en |=> (pin == $past(fw_lvl)));

  p_level_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && !edge_sel) |=> (pin == ($past(req) ^ $past(inv_pol))));

  p_pulse_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hw_en && edge_sel && req && !req_q) |=> (cnt_q == $past(width)));

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/hostirq_gen.sv
module hostirq_gen
  import hostirq_pkg::*;
#(
  parameter int unsigned MODE_W   = 2,
  parameter int unsigned BASE_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 obf_kbm,
  input  logic                 last_wr_mouse,
  input  logic                 obf_pm,
  input  logic [NUM_LINES-1:0] hw_en,
  input  logic [NUM_LINES-1:0] fw_lvl,
  input  logic [MODE_W-1:0]    pulse_mode,
  input  logic                 inv_pol,
  output logic [NUM_LINES-1:0] irq_pin,
  output logic [NUM_LINES-1:0] irq_rdbk
);
  localparam int unsigned MAX_PULSE = BASE_CYC << ((1 << MODE_W) - 2);
  localparam int unsigned CNT_W     = $clog2(MAX_PULSE + 1);

  logic [NUM_LINES-1:0] req;
  logic                 edge_sel;
  logic [CNT_W-1:0]     width;

  hostirq_steer u_steer (
    .obf_kbm       (obf_kbm),
    .last_wr_mouse (last_wr_mouse),
    .obf_pm        (obf_pm),
    .req           (req)
  );

  hostirq_width #(
    .MODE_W   (MODE_W),
    .BASE_CYC (BASE_CYC),
    .CNT_W    (CNT_W)
  ) u_width (
    .pulse_mode (pulse_mode),
    .edge_sel   (edge_sel),
    .width      (width)
  );

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    hostirq_line #(.CNT_W(CNT_W)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req[gi]),
      .hw_en    (hw_en[gi]),
      .fw_lvl   (fw_lvl[gi]),
      .edge_sel (edge_sel),
      .width    (width),
      .inv_pol  (inv_pol),
      .pin      (irq_pin[gi])
    );
  end

  // R9: readback mirrors the pins
  assign irq_rdbk = irq_pin;

  p_mouse_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (obf_kbm && !last_wr_mouse && !obf_pm && (hw_en == 3'b111) &&
     (pulse_mode == '0) && !inv_pol)
    |=> (irq_pin == 3'b001));
endmodule

// File: tb/hostirq_gen_bench.sv
module hostirq_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       obf_kbm, last_wr_mouse, obf_pm, inv_pol;
  logic [2:0] hw_en, fw_lvl;
  logic [1:0] pulse_mode;
  logic [2:0] irq_pin, irq_rdbk;

  // driver-side copies
  logic       d_kbm, d_sel, d_pm, d_inv;
  logic [2:0] d_hw, d_fw;
  logic [1:0] d_mode;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  // model state
  logic [2:0] m_prev = '0;
  int         m_cnt[3] = '{0, 0, 0};

  always #2 clk = ~clk;

  hostirq_gen u_hostirq_gen (
    .clk(clk), .rst_n(rst_n), .obf_kbm(obf_kbm), .last_wr_mouse(last_wr_mouse),
    .obf_pm(obf_pm), .hw_en(hw_en), .fw_lvl(fw_lvl), .pulse_mode(pulse_mode),
    .inv_pol(inv_pol), .irq_pin(irq_pin), .irq_rdbk(irq_rdbk)
  );

  task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply one cycle of stimulus and push the predicted pins
  task automatic step(input string tag);
    logic [2:0] req, exp;
    @(negedge clk);
    obf_kbm = d_kbm; last_wr_mouse = d_sel; obf_pm = d_pm;
    hw_en = d_hw; fw_lvl = d_fw; pulse_mode = d_mode; inv_pol = d_inv;
    req = {d_pm, d_kbm & d_sel, d_kbm & ~d_sel};
    for (int i = 0; i < 3; i++) begin
      if (m_cnt[i] != 0) m_cnt[i]--;
      else if (d_hw[i] && d_mode != 0 && req[i] && !m_prev[i])
        m_cnt[i] = 4 << (d_mode - 1);
      if (!d_hw[i]) exp[i] = d_fw[i];
      else if (d_mode != 0) exp[i] = (m_cnt[i] == 0) ^ d_inv;
      else exp[i] = req[i] ^ d_inv;
    end
    m_prev = req;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic run(input string tag, input int n);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check3(t, irq_pin, e);
        check3("R9 readback", irq_rdbk, irq_pin);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    d_kbm = 0; d_sel = 0; d_pm = 0; d_inv = 0; d_hw = '0; d_fw = '0; d_mode = '0;
    obf_kbm = 0; last_wr_mouse = 0; obf_pm = 0; inv_pol = 0;
    hw_en = '0; fw_lvl = 3'b111; pulse_mode = 2'd2;
    repeat (3) @(negedge clk);
    check3("R1 reset pins", irq_pin, 3'b000);
    check3("R1 reset readback", irq_rdbk, 3'b000);
    fw_lvl = '0; pulse_mode = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2: firmware drive ignores flags, mode and polarity
    d_hw = 3'b000; d_mode = 2'd2; d_inv = 1;
    d_fw = 3'b101; d_kbm = 1; d_pm = 0; run("R2 fw drive", 2);
    d_fw = 3'b010; d_kbm = 0; d_pm = 1; run("R2 fw drive", 2);
    d_fw = 3'b111; d_pm = 0;            run("R2 fw drive", 2);
    d_fw = 3'b000;                      run("R2 fw drive", 2);

    // R3/R4: level mode and steering
    d_inv = 0; d_mode = 0; d_hw = 3'b111;
    d_kbm = 1; d_sel = 0; run("R3 R4 kbd level", 3);
    d_sel = 1;            run("R3 R4 mouse level", 3);
    d_kbm = 0;            run("R4 level drop", 2);
    d_pm = 1;             run("R4 pm level", 2);
    d_pm = 0;             run("R4 pm drop", 2);
    d_hw = 3'b101; d_fw = 3'b010; d_kbm = 1; d_sel = 0; run("R2 mixed", 3);
    d_kbm = 0; d_hw = 3'b111; d_fw = 0; run("R4 idle", 2);

    // R5/R6: edge pulses of each width
    d_mode = 1; run("R5 edge idle", 2);
    d_pm = 1;   run("R5 R6 pm width4", 8);
    d_pm = 0; d_kbm = 1; d_sel = 0; run("R5 R6 kbd width4", 8);
    d_kbm = 0; d_mode = 2; run("R5 idle", 2);
    d_kbm = 1; d_sel = 1; run("R6 mouse width8", 12);
    d_kbm = 0; d_mode = 3; run("R5 idle", 2);
    d_pm = 1;  run("R6 pm width16", 20);

    // R7: rise during a pulse is ignored
    d_pm = 0; d_mode = 2; run("R7 setup", 2);
    d_pm = 1; run("R7 first rise", 2);
    d_pm = 0; run("R7 gap", 1);
    d_pm = 1; run("R7 rise in pulse", 10);
    d_pm = 0; run("R7 settle", 2);

    // R8: inverted polarity in both modes
    d_inv = 1; d_mode = 0;
    d_kbm = 1; d_sel = 0; run("R8 level inverted", 3);
    d_kbm = 0; d_pm = 1;  run("R8 level inverted", 2);
    d_pm = 0; d_mode = 1; run("R8 edge idle inverted", 2);
    d_pm = 1;             run("R8 edge inverted pulse", 8);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule